// File: doc/BRIEF.md
# UART Channel Enable Controller

This block holds the transmitter and receiver enable state of one UART channel and interprets writes to that channel's 8-bit command register. One write carries three things: a change-permit flag in bit 7, the transmitter and receiver enable values in bits 6 and 5, and a 5-bit command code in bits 4:0. The code is passed on as a registered one-cycle strobe to command logic outside this block. The enable values are applied only when the permit flag is set. Software can therefore issue commands without knowing or disturbing the current enable state.

The transmitter FIFO, the shift register and the receiver all sit outside the block. The controller learns their state from a FIFO-empty flag, a shifter-busy flag and a wake-up mode select. It drives a transmitter run signal, a receiver active signal and a receiver abort pulse. It also produces the transmitter ready and transmitter idle status flags. Turning the transmitter off is graceful: the run signal stays high until the queued data has gone out. Turning the receiver off takes effect at once and discards any partial character. Neither kind of disable acts as a reset, so FIFO contents and error state are left untouched.

Top module: `uart_chan_enable`

## Requirements
- R1: After asynchronous reset, both enables read as 0, txRun=0, txRdy=0, txIdle=1, cmdStrobe=0 and rxAbort=0. rxActive=0 while wakeMode=0.
- R2: A write to the command address with bit 7 = 0 leaves both stored enables unchanged, whatever bits 6:5 hold.
- R3: A write to the command address with bit 7 = 1 loads the transmitter enable from bit 6 and the receiver enable from bit 5 (1 = on). The new values appear on the next cycle.
- R4: Every write to the command address (0x12) pulses cmdStrobe high for exactly one cycle, on the cycle after the write. In that cycle cmdCode equals write bits 4:0, and cmdCode holds that value until the next such write.
- R5: Turning the transmitter on sets txRun=1, txRdy=1 and txIdle=0 on the next cycle.
- R6: Turning the transmitter off clears txRdy and txIdle on the next cycle. txRun stays 1 while txShiftBusy=1 or txFifoEmpty=0. txRun falls, and txIdle rises, on the clock edge at which both txShiftBusy=0 and txFifoEmpty=1 are seen with the transmitter off.
- R7: rxActive follows the receiver enable one cycle after the write. Turning an enabled receiver off pulses rxAbort for one cycle. A disable write with the receiver already off gives no pulse.
- R8: While wakeMode=1, rxActive is 1 regardless of the receiver enable. The effect is combinational.
- R9: A read at the command address returns the transmitter enable in bit 6, the receiver enable in bit 5, and 0 in all other bits. A read at any other address returns 0.
- R10: A write to any other address changes no enable or status and produces no cmdStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write qualifier |
| addr | input | ADDR_W (8) | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| txFifoEmpty | input | 1 | Transmit FIFO holds no characters |
| txShiftBusy | input | 1 | Transmit shifter is sending a character |
| wakeMode | input | 1 | Wake-up mode selected; keeps receiver running |
| txRun | output | 1 | Transmitter allowed to run |
| txRdy | output | 1 | Transmitter ready status |
| txIdle | output | 1 | Transmitter idle status |
| rxActive | output | 1 | Receiver searching/receiving |
| rxAbort | output | 1 | One-cycle pulse: drop partial character |
| cmdStrobe | output | 1 | One-cycle pulse per command write |
| cmdCode | output | 5 | Command code from the last command write |

## Verification
A wrong stored enable shows up at the read port and on rxActive or txRun one cycle after the write that caused it, so each write is followed by a comparison of every output in the very next cycle. A faulty drain condition is subtler. It appears only while the transmitter is off and one of the busy inputs is still asserted: txRun then drops early, or stays high after both become idle. For that reason the drain is exercised with the two idle conditions released in turn. A lost or duplicated command strobe appears in the single cycle after a write, so a strobe count against write count catches it.

// File: rtl/chan_en_pkg.sv
package chan_en_pkg;
  localparam int CMD_W    = 5;
  localparam int LOCK_BIT = 7;
  localparam int TX_BIT   = 6;
  localparam int RX_BIT   = 5;

  typedef struct packed {
    logic             hit;    // write to the command address
    logic             chg;    // enable change permitted
    logic             txNew;
    logic             rxNew;
    logic [CMD_W-1:0] code;
  } cmdStrobes_t;
endpackage

// File: rtl/chan_en_decode.sv
module chan_en_decode
  import chan_en_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h12
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEnQ,
  input  logic              rxEnQ,
  output cmdStrobes_t       strb,
  output logic [DATA_W-1:0] rdData
);
  logic addrHit;
  assign addrHit = (addr == CMD_ADDR);

  always_comb begin
    strb.hit   = wrEn & addrHit;
    strb.chg   = wrEn & addrHit & wrData[LOCK_BIT];
    strb.txNew = wrData[TX_BIT];
    strb.rxNew = wrData[RX_BIT];
    strb.code  = wrData[CMD_W-1:0];
  end

  always_comb begin
    rdData = '0;
    if (addrHit) begin
      rdData[TX_BIT] = txEnQ;
      rdData[RX_BIT] = rxEnQ;
    end
  end
endmodule

// File: rtl/chan_en_state.sv
module chan_en_state
  import chan_en_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobes_t      strb,
  input  logic             txFifoEmpty,
  input  logic             txShiftBusy,
  input  logic             wakeMode,
  output logic             txEnQ,
  output logic             rxEnQ,
  output logic             txRun,
  output logic             txRdy,
  output logic             txIdle,
  output logic             rxActive,
  output logic             rxAbort,
  output logic             cmdStrobe,
  output logic [CMD_W-1:0] cmdCode
);
  logic drainDone;
  assign drainDone = ~txEnQ & ~txIdle & ~txShiftBusy & txFifoEmpty;
  assign rxActive  = rxEnQ | wakeMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ     <= 1'b0;
      rxEnQ     <= 1'b0;
      txRun     <= 1'b0;
      txRdy     <= 1'b0;
      txIdle    <= 1'b1;
      rxAbort   <= 1'b0;
      cmdStrobe <= 1'b0;
      cmdCode   <= '0;
    end else begin
      cmdStrobe <= strb.hit;
      rxAbort   <= 1'b0;
      if (strb.hit) cmdCode <= strb.code;
      if (strb.chg) begin
        rxEnQ   <= strb.rxNew;
        rxAbort <= rxEnQ & ~strb.rxNew;
        txEnQ   <= strb.txNew;
        txRdy   <= strb.txNew;
        txIdle  <= 1'b0;
        if (strb.txNew) txRun <= 1'b1;
      end else if (drainDone) begin
        txRun  <= 1'b0;
        txIdle <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_chan_enable.sv
module uart_chan_enable
  import chan_en_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              txFifoEmpty,
  input  logic              txShiftBusy,
  input  logic              wakeMode,
  output logic              txRun,
  output logic              txRdy,
  output logic              txIdle,
  output logic              rxActive,
  output logic              rxAbort,
  output logic              cmdStrobe,
  output logic [CMD_W-1:0]  cmdCode
);
  cmdStrobes_t strb;
  logic txEnQ, rxEnQ;

  chan_en_decode #(.ADDR_W(ADDR_W), .DATA_W(8), .CMD_ADDR(CMD_ADDR)) u_dec (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .txEnQ(txEnQ), .rxEnQ(rxEnQ), .strb(strb), .rdData(rdData)
  );

  chan_en_state u_st (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txFifoEmpty(txFifoEmpty), .txShiftBusy(txShiftBusy), .wakeMode(wakeMode),
    .txEnQ(txEnQ), .rxEnQ(rxEnQ), .txRun(txRun), .txRdy(txRdy), .txIdle(txIdle),
    .rxActive(rxActive), .rxAbort(rxAbort), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
  );
endmodule

// File: rtl/chan_en_chk.sv
module chan_en_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic              txShiftBusy,
  input logic              wakeMode,
  input logic              txEnQ,
  input logic              rxEnQ,
  input logic              txRun,
  input logic              txRdy,
  input logic              txIdle,
  input logic              rxActive,
  input logic              rxAbort,
  input logic              cmdStrobe
);
  logic wrHit;
  assign wrHit = wrEn && (addr == CMD_ADDR);

  assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrHit && !wrData[7] |=> $stable(txEnQ) && $stable(rxEnQ));

  assert_strobe_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> cmdStrobe);

  assert_no_stray_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> !cmdStrobe);

  assert_tx_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrHit && wrData[7] && wrData[6] |=> txRun && txRdy && !txIdle);

  assert_tx_drain_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    txRun && !txEnQ && txShiftBusy |=> txRun);

  assert_idle_excludes_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> !txRun);

  assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |=> !rxAbort);

  assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |-> !rxEnQ && $past(rxEnQ));

  assert_wake_keeps_rx_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeMode |-> rxActive);
endmodule

bind uart_chan_enable chan_en_chk #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .txShiftBusy(txShiftBusy), .wakeMode(wakeMode), .txEnQ(txEnQ), .rxEnQ(rxEnQ),
  .txRun(txRun), .txRdy(txRdy), .txIdle(txIdle), .rxActive(rxActive),
  .rxAbort(rxAbort), .cmdStrobe(cmdStrobe)
);

// File: tb/sim_uart_chan_enable.sv
`timescale 1ns/1ps
module sim_uart_chan_enable;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic       txFifoEmpty = 1'b1;
  logic       txShiftBusy = 1'b0;
  logic       wakeMode = 1'b0;
  logic [7:0] rdData;
  logic       txRun, txRdy, txIdle, rxActive, rxAbort, cmdStrobe;
  logic [4:0] cmdCode;

  always #2 clk = ~clk;

  uart_chan_enable u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .txFifoEmpty(txFifoEmpty), .txShiftBusy(txShiftBusy), .wakeMode(wakeMode),
    .txRun(txRun), .txRdy(txRdy), .txIdle(txIdle), .rxActive(rxActive),
    .rxAbort(rxAbort), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
  );

  typedef struct {
    logic [7:0] rd;
    logic       run, rdy, idle, act, abt, stb;
    logic [4:0] code;
    string      tag;
  } expItem_t;

  expItem_t   sbQ[$];
  int         nChecks = 0;
  int         nFails  = 0;
  bit         finished = 0;

  // reference model state
  logic       mTx = 0, mRx = 0, mRun = 0, mIdle = 1;
  logic [4:0] mCode = 0;

  function automatic string fmt(expItem_t e);
    return $sformatf("rd=%02h run=%0b rdy=%0b idle=%0b act=%0b abt=%0b stb=%0b code=%02h",
                     e.rd, e.run, e.rdy, e.idle, e.act, e.abt, e.stb, e.code);
  endfunction

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic fe, input logic busy, input logic wk, input string tag);
    expItem_t e;
    logic hit, chg, abt;
    @(negedge clk); #1;
    wrEn = w; addr = a; wrData = d; txFifoEmpty = fe; txShiftBusy = busy; wakeMode = wk;
    hit = w && (a == 8'h12);
    chg = hit && d[7];
    abt = chg && !d[5] && mRx;
    if (hit) mCode = d[4:0];
    if (chg) begin
      mRx = d[5]; mTx = d[6]; mIdle = 0;
      if (d[6]) mRun = 1;
    end else if (!mTx && !mIdle && !busy && fe) begin
      mRun = 0; mIdle = 1;
    end
    e.rd   = (a == 8'h12) ? {1'b0, mTx, mRx, 5'b0} : 8'h00;
    e.run  = mRun; e.rdy = mTx; e.idle = mIdle;
    e.act  = mRx | wk; e.abt = abt; e.stb = hit; e.code = mCode;
    e.tag  = tag;
    sbQ.push_back(e);
  endtask

  // monitor: compares one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t e, g;
      e = sbQ.pop_front();
      g.rd = rdData; g.run = txRun; g.rdy = txRdy; g.idle = txIdle;
      g.act = rxActive; g.abt = rxAbort; g.stb = cmdStrobe; g.code = cmdCode;
      nChecks++;
      if (g.rd !== e.rd || g.run !== e.run || g.rdy !== e.rdy || g.idle !== e.idle ||
          g.act !== e.act || g.abt !== e.abt || g.stb !== e.stb || g.code !== e.code) begin
        nFails++;
        $display("FAIL %s: actual {%s} expected {%s}", e.tag, fmt(g), fmt(e));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #20000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    addr = 8'h12;
    repeat (3) @(negedge clk);
    // R1 reset state
    nChecks++;
    if (rdData !== 8'h00 || txRun !== 0 || txRdy !== 0 || txIdle !== 1 ||
        rxActive !== 0 || rxAbort !== 0 || cmdStrobe !== 0) begin
      nFails++;
      $display("FAIL R1: actual rd=%02h run=%0b rdy=%0b idle=%0b act=%0b abt=%0b stb=%0b expected rd=00 run=0 rdy=0 idle=1 act=0 abt=0 stb=0",
               rdData, txRun, txRdy, txIdle, rxActive, rxAbort, cmdStrobe);
    end
    @(negedge clk); rstN = 1'b1;

    step(0, 8'h12, 8'h00, 1, 0, 0, "R9 idle read");
    // R2: locked write with both enable bits set
    step(1, 8'h12, 8'h63, 1, 0, 0, "R2 locked write ignores 6:5");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R4 strobe single cycle");
    // R3 / R5 / R7: enable both
    step(1, 8'h12, 8'hE4, 1, 0, 0, "R3 R5 R7 enable both");
    step(0, 8'h12, 8'h00, 0, 1, 0, "R5 enabled steady");
    // R2: locked write with zeros must keep enables
    step(1, 8'h12, 8'h0B, 0, 1, 0, "R2 locked write keeps enables");
    // R10: write elsewhere
    step(1, 8'h13, 8'h80, 0, 1, 0, "R10 other address ignored");
    step(0, 8'h44, 8'h00, 0, 1, 0, "R9 other address reads zero");
    // R6: disable tx while busy and FIFO not empty
    step(1, 8'h12, 8'hA1, 0, 1, 0, "R6 tx disable clears rdy idle");
    step(0, 8'h12, 8'h00, 0, 1, 0, "R6 hold while busy");
    step(0, 8'h12, 8'h00, 0, 0, 0, "R6 hold while fifo not empty");
    step(0, 8'h12, 8'h00, 1, 1, 0, "R6 hold while shifter busy");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R6 run falls idle rises");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R6 stays idle");
    // R7: rx disable with abort, then again without
    step(1, 8'h12, 8'h9F, 1, 0, 0, "R7 rx disable abort pulse");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R7 abort single cycle");
    step(1, 8'h12, 8'h80, 1, 0, 0, "R7 no abort when already off");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R6 disable with nothing queued");
    // R8: wake-up mode
    step(0, 8'h12, 8'h00, 1, 0, 1, "R8 wake keeps rx active");
    step(1, 8'h12, 8'h15, 1, 0, 1, "R8 R4 wake plus locked command");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R8 wake removed");
    // R5 re-enable tx only, back-to-back writes
    step(1, 8'h12, 8'hC2, 1, 0, 0, "R5 re-enable tx");
    step(1, 8'h12, 8'hA3, 1, 0, 0, "R3 swap enables back to back");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R6 drain after swap");
    step(0, 8'h12, 8'h00, 1, 0, 0, "R9 final read");
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule